// File: doc/BRIEF.md
# Edge-Triggered Wake-Up Interrupt Flag Register

This block captures signal edges on six asynchronous wake-up pins and holds a sticky request flag for each one inside an 8-bit register that software reads and clears. Each pin first crosses into the clock domain through a synchronizer. A per-pin select input chooses whether a rising or a falling transition counts as an event. When a pin's enable input is high, an event on that pin sets its flag.

Software clears flags by writing zero to the bits it wants to clear. A one in any write bit leaves the matching flag as it is, so a mask with zeros only in the chosen positions clears just those flags. The two top bits are reserved. They always read as one, which gives a reset value of 0xC0. The interrupt request output stays high while any flag is set. Taking the interrupt does not clear anything, and only a software write removes a flag.

Top module: `wake_flag_reg`

## Requirements
- R1: While reset is high and right after it, reg_rdata reads 0xC0 and irq is 0.
- R2: Bits 7 and 6 of reg_rdata always read 1. Writing 0 to them changes nothing.
- R3: When edge_fall[n] is 0 (rising select), a 0 to 1 change on wake_pin[n] with pin_en[n]=1 sets bit n of reg_rdata. The bit reads 1 after the third rising clock edge that follows the pin change and not before.
- R4: When edge_fall[n] is 1 (falling select), a 1 to 0 change on wake_pin[n] with pin_en[n]=1 sets bit n, with the same latency as R3. The opposite transition does not set it.
- R5: An edge on a pin whose pin_en bit is 0 never sets its flag. A flag that is already set stays set when its enable is later removed.
- R6: A write (reg_sel=1, reg_wr=1) clears every flag bit n where reg_wdata[n]=0 and leaves every flag where reg_wdata[n]=1 unchanged. The new value is visible after that clock edge.
- R7: If an edge that sets flag n is taken in the same clock cycle as a write of 0 to bit n, the flag ends up 1.
- R8: A flag that is set stays set through any number of cycles until a write clears it. Reading has no side effect.
- R9: irq is 1 exactly when any of reg_rdata[5:0] is 1.
- R10: reg_wr with reg_sel=0 changes no flag.
- R11: The pin levels present while reset is high do not count as edges once reset is released. A pin held high through reset, with rising select, leaves its flag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_pin | input | 6 | Asynchronous wake-up pin levels |
| edge_fall | input | 6 | Per-pin edge select: 0 rising, 1 falling |
| pin_en | input | 6 | Per-pin interrupt enable |
| reg_sel | input | 1 | Register address match |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data; zero bits clear flags |
| reg_rdata | output | 8 | Register contents, reserved bits high |
| irq | output | 1 | Request, high while any flag is set |

## Verification
The assertions check four things on every cycle. A flag falls only after a write that carried zero in its bit. A flag rises only on an enabled pin. A taken edge always leaves its flag set, even when a clearing write lands in the same cycle. The registered request always matches the flag vector. Other behaviour can only be shown by the bench's scenarios: the exact three-cycle latency from pin to flag, the rising and falling selection, the quiet start-up after reset, and the reserved bits surviving writes. The bench's random run compares every cycle against an independent cycle model.

// File: rtl/wkf_pkg.sv
package wkf_pkg;
  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_kind_e;

  function automatic logic edge_match(input logic now_lvl, input logic old_lvl,
                                      input edge_kind_e kind);
    return (kind == EDGE_RISE) ? (now_lvl & ~old_lvl) : (~now_lvl & old_lvl);
  endfunction
endpackage

// File: rtl/wkf_sync.sv
module wkf_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/wkf_edge_det.sv
module wkf_edge_det
  import wkf_pkg::*;
#(
  parameter int W           = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] fall_sel,
  output logic [W-1:0] hit
);
  localparam int ARM_LIM = SYNC_STAGES + 1;
  localparam int CW      = $clog2(ARM_LIM + 1);

  logic [W-1:0]  prev_q;
  logic [CW-1:0] arm_q;
  logic          armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      arm_q  <= '0;
    end else begin
      prev_q <= lvl;
      if (arm_q != CW'(ARM_LIM)) arm_q <= arm_q + 1'b1;
    end
  end

  assign armed = (arm_q == CW'(ARM_LIM));

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign hit[i] = armed & edge_match(lvl[i], prev_q[i], edge_kind_e'(fall_sel[i]));
  end
endmodule

// File: rtl/wkf_flag_bank.sv
module wkf_flag_bank #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] hit,
  input  logic [W-1:0] en,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_bits,
  output logic [W-1:0] flags,
  output logic         irq
);
  logic [W-1:0] set_v, clr_v, next_v;

  assign set_v  = hit & en;
  assign clr_v  = wr_stb ? ~wr_bits : '0;
  assign next_v = (flags & ~clr_v) | set_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= next_v;
      irq   <= |next_v;
    end
  end

  // R9: registered request tracks the flag vector
  a_r9_irq_tracks: assert property (@(posedge clk) disable iff (rst)
    irq == (|flags));

  for (genvar i = 0; i < W; i++) begin : g_chk
    // R8: a flag only drops after a write with zero in its bit
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
      $fell(flags[i]) |-> $past(wr_stb && !wr_bits[i]));
    // R5: a flag only rises on an enabled pin
    a_r5_enable_gate: assert property (@(posedge clk) disable iff (rst)
      $rose(flags[i]) |-> $past(en[i]));
    // R7: a taken edge always leaves the flag set
    a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
      (hit[i] && en[i]) |=> flags[i]);
    // R6: writing one keeps a set flag
    a_r6_one_keeps: assert property (@(posedge clk) disable iff (rst)
      (wr_stb && wr_bits[i] && flags[i]) |=> flags[i]);
  end
endmodule

// File: rtl/wake_flag_reg.sv
module wake_flag_reg #(
  parameter int NUM_PINS    = 6,
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] wake_pin,
  input  logic [NUM_PINS-1:0] edge_fall,
  input  logic [NUM_PINS-1:0] pin_en,
  input  logic                reg_sel,
  input  logic                reg_wr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  output logic                irq
);
  localparam int RSV_W = REG_W - NUM_PINS;

  logic [NUM_PINS-1:0] sync_lvl, edge_hit, flag_q;
  logic                wr_stb;

  assign wr_stb = reg_sel & reg_wr;

  wkf_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(wake_pin), .dout(sync_lvl)
  );

  wkf_edge_det #(.W(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .lvl(sync_lvl), .fall_sel(edge_fall), .hit(edge_hit)
  );

  wkf_flag_bank #(.W(NUM_PINS)) u_flags (
    .clk(clk), .rst(rst), .hit(edge_hit), .en(pin_en), .wr_stb(wr_stb),
    .wr_bits(reg_wdata[NUM_PINS-1:0]), .flags(flag_q), .irq(irq)
  );

  assign reg_rdata = {{RSV_W{1'b1}}, flag_q};

  // R10: an unselected write leaves the flags as they were or sets more
  a_r10_unselected: assert property (@(posedge clk) disable iff (rst)
    (!reg_sel && $past(!rst)) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
endmodule

// File: tb/sim_wake_flag_reg.sv
module sim_wake_flag_reg;
  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] wake_pin, edge_fall, pin_en;
  logic       reg_sel, reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq;

  int n_checks = 0;
  int n_errors = 0;

  logic [5:0] m1, m2, mprev, mflags;
  int         marm;

  always #4 clk = ~clk;

  wake_flag_reg u0 (
    .clk(clk), .rst(rst), .wake_pin(wake_pin), .edge_fall(edge_fall),
    .pin_en(pin_en), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [7:0] exp_reg();
    return {2'b11, mflags};
  endfunction

  task automatic model_step();
    logic [5:0] set_v, clr_v;
    logic       armed;
    if (rst) begin
      m1 = '0; m2 = '0; mprev = '0; mflags = '0; marm = 0;
    end else begin
      armed = (marm == 3);
      for (int i = 0; i < 6; i++)
        set_v[i] = armed && pin_en[i] &&
                   (edge_fall[i] ? (!m2[i] && mprev[i]) : (m2[i] && !mprev[i]));
      clr_v  = (reg_sel && reg_wr) ? ~reg_wdata[5:0] : 6'h00;
      mflags = (mflags & ~clr_v) | set_v;
      mprev  = m2; m2 = m1; m1 = wake_pin;
      if (marm < 3) marm++;
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_model(input string req);
    check(reg_rdata == exp_reg(), req, reg_rdata, exp_reg());
    check(irq == (|mflags), {req, "/R9 irq"}, {7'd0, irq}, {7'd0, |mflags});
  endtask

  task automatic cyc(input string req);
    @(posedge clk);
    @(negedge clk);
    model_step();
    cmp_model(req);
  endtask

  task automatic reg_write(input logic [7:0] d, input logic sel, input string req);
    reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
    cyc(req);
    reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    rst = 1'b1; wake_pin = 6'h3F; edge_fall = 6'h00; pin_en = 6'h3F;
    reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
    repeat (3) cyc("R1 reset");
    check(reg_rdata == 8'hC0, "R1 reset value", reg_rdata, 8'hC0);
    rst = 1'b0;
    // R11: pins high through reset with rising select, no flag
    repeat (8) cyc("R11 quiet start");
    check(reg_rdata == 8'hC0, "R11 no startup edge", reg_rdata, 8'hC0);
    check(irq == 1'b0, "R1 irq idle", {7'd0, irq}, 8'h00);

    wake_pin = 6'h00;
    repeat (5) cyc("R3 idle");
    // R3: rising edge on pin 2, visible after the third clock edge
    wake_pin[2] = 1'b1;
    cyc("R3"); cyc("R3");
    check(reg_rdata == 8'hC0, "R3 not early", reg_rdata, 8'hC0);
    cyc("R3");
    check(reg_rdata == 8'hC4, "R3 rising set", reg_rdata, 8'hC4);
    check(irq == 1'b1, "R9 irq on", {7'd0, irq}, 8'h01);

    // R4: falling select on pin 5; a rise first must not set it
    edge_fall[5] = 1'b1;
    wake_pin[5] = 1'b1;
    repeat (5) cyc("R4 rise ignored");
    check(reg_rdata == 8'hC4, "R4 rise ignored", reg_rdata, 8'hC4);
    wake_pin[5] = 1'b0;
    repeat (3) cyc("R4");
    check(reg_rdata == 8'hE4, "R4 falling set", reg_rdata, 8'hE4);

    // R2 and R6: ones keep everything, reserved stay high
    reg_write(8'hFF, 1'b1, "R6 write ones");
    check(reg_rdata == 8'hE4, "R6 ones keep", reg_rdata, 8'hE4);
    reg_write(8'h3B, 1'b1, "R2 reserved");
    check(reg_rdata == 8'hE0, "R2/R6 clear bit2", reg_rdata, 8'hE0);

    // R10: write without select
    reg_write(8'h00, 1'b0, "R10");
    check(reg_rdata == 8'hE0, "R10 unselected write", reg_rdata, 8'hE0);

    // R5: disabled pin 1 ignored; enabled pin 0 set then disabled stays
    pin_en[1] = 1'b0;
    wake_pin[1] = 1'b1; wake_pin[0] = 1'b1;
    repeat (4) cyc("R5");
    check(reg_rdata == 8'hE1, "R5 disabled ignored", reg_rdata, 8'hE1);
    pin_en[0] = 1'b0;
    repeat (4) cyc("R5 keep");
    check(reg_rdata == 8'hE1, "R5 flag kept after disable", reg_rdata, 8'hE1);

    // R7: set wins over a same-cycle clear on pin 3
    wake_pin[3] = 1'b1;
    repeat (4) cyc("R7 prep");
    wake_pin[3] = 1'b0;
    repeat (4) cyc("R7 prep");
    wake_pin[3] = 1'b1;
    cyc("R7"); cyc("R7");
    reg_write(8'hF7, 1'b1, "R7 collide");
    check(reg_rdata == 8'hE9, "R7 set wins", reg_rdata, 8'hE9);

    // R8: flags hold with no writes
    repeat (20) cyc("R8 sticky");
    check(reg_rdata == 8'hE9, "R8 sticky hold", reg_rdata, 8'hE9);
    reg_write(8'h00, 1'b1, "R6 clear all");
    check(reg_rdata == 8'hC0, "R6 all cleared", reg_rdata, 8'hC0);
    check(irq == 1'b0, "R9 irq off", {7'd0, irq}, 8'h00);

    // Random traffic against the model
    for (int t = 0; t < 3000; t++) begin
      wake_pin = 6'($urandom);
      if (($urandom % 16) == 0) edge_fall = 6'($urandom);
      if (($urandom % 16) == 0) pin_en = 6'($urandom);
      reg_sel = (($urandom % 6) == 0);
      reg_wr = (($urandom % 2) == 0);
      reg_wdata = 8'($urandom);
      cyc("R9 random");
    end
    reg_sel = 1'b0; reg_wr = 1'b0;

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule